// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block collects 28 external interrupt request lines, gives each its own trigger condition, and records detected events in a pending register. Every line first passes a synchroniser. A detector then fires on a rising edge, a falling edge, either edge, a low level or a high level, as the line's trigger field selects. A detected event sets a pending bit. Software clears a pending bit by writing a one to it. A mask bit per line stops that line from raising an interrupt. The pending bit still records events while the line is masked.

Active lines are OR-merged into four interrupt outputs of uneven size for an upstream vectored interrupt controller. The first output serves four lines and the other three serve eight lines each. Software reaches the two trigger-configuration words, the mask and the pending register over a simple synchronous register bus. Reads return data one cycle after the request.

Top module: `eint_ctrl`

## Requirements
- R1: After reset both configuration words read 0, the mask reads 0x0FFFFFFF (all lines masked) and every bit of `irq_o` is 0.
- R2: The bus selects a register with `addr_i`: 0 is configuration word A, 1 is configuration word B, 2 is the mask and 3 is the pending register. A read returns data on `rdata_o` in the cycle after the request, and `rdata_o` holds its value when no read is made. Bit 3 of every nibble in the configuration words reads 0. So do bits 31:24 of word B and bits 31:28 of the mask and the pending register.
- R3: A change on an input line reaches `irq_o` on the third rising clock edge after it is applied: two synchroniser stages, then the pending register.
- R4: In rising-edge mode (field 10x) a 0-to-1 transition sets the pending bit, and a 1-to-0 transition does not.
- R5: In falling-edge mode (field 01x) a 1-to-0 transition sets the pending bit, and a 0-to-1 transition does not.
- R6: In both-edge mode (field 11x) either transition sets the pending bit.
- R7: In high-level mode (field 001) the pending bit is set again on every cycle while the input is high, so a clear does not take effect until the input has gone low.
- R8: In low-level mode (field 000) the pending bit is set again on every cycle while the input is low.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R10: Mask bit n set to 1 keeps line n off its output while its pending bit still records events. Clearing the mask bit lets a held pending bit drive the output.
- R11: `irq_o[0]` is the OR of active lines 0–3, `irq_o[1]` of lines 4–11, `irq_o[2]` of lines 12–19 and `irq_o[3]` of lines 20–27. A line is active when it is pending and unmasked.
- R12: Lines 2k and 2k+1 share one 3-bit field. For lines 0–15 the field is at bits (n/2)*4+2:(n/2)*4 of word A. For lines 16–27 it is at bits ((n-16)/2)*4+2:((n-16)/2)*4 of word B.
- R13: An event in the same cycle as a write-1-to-clear of that line leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 28 | External interrupt request lines, asynchronous |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 4 | Grouped interrupt outputs |

## Verification
The bench builds the block with its default parameters: 28 lines and a two-stage synchroniser. This lets it place probes on the first and last line of every group and on lines in both configuration words. The fixed two-stage depth lets it check the three-edge latency exactly. The bench also times a clear write to land on the same edge as a fresh event.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int NUM_LINES     = 28;
  localparam int DATA_W        = 32;
  localparam int LINES_PER_CFG = 16;
  localparam int FIELD_W       = 3;
  localparam int FIELD_STRIDE  = 4;
  localparam int NUM_FIELDS    = NUM_LINES / 2;
  localparam int CFG_A_FIELDS  = LINES_PER_CFG / 2;
  localparam int CFG_B_FIELDS  = NUM_FIELDS - CFG_A_FIELDS;
  localparam int NUM_GROUPS    = 4;
  localparam int GRP_FIRST     = 4;
  localparam int GRP_SIZE      = 8;

  typedef enum logic [1:0] {
    REG_CFG_A = 2'd0,
    REG_CFG_B = 2'd1,
    REG_MASK  = 2'd2,
    REG_PEND  = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] cfg_valid(input int nfields);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int f = 0; f < nfields; f++) m[f*FIELD_STRIDE +: FIELD_W] = '1;
    return m;
  endfunction

  function automatic logic trig_hit(input logic [FIELD_W-1:0] f, input logic cur,
                                    input logic prv);
    logic hit;
    unique case (f[2:1])
      2'b00:   hit = f[0] ? cur : ~cur;
      2'b01:   hit = prv & ~cur;
      2'b10:   hit = ~prv & cur;
      default: hit = prv ^ cur;
    endcase
    return hit;
  endfunction

  function automatic int grp_lo(input int g);
    return (g == 0) ? 0 : GRP_FIRST + (g - 1) * GRP_SIZE;
  endfunction

  function automatic int grp_hi(input int g);
    return GRP_FIRST + g * GRP_SIZE - 1;
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int W = NUM_LINES
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [W-1:0]                      lvl_i,
  input  logic [W/2-1:0][FIELD_W-1:0]       fields_i,
  output logic [W-1:0]                      evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign evt_o[i] = trig_hit(fields_i[i/2], lvl_i[i], prev_q[i]);
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int W = NUM_LINES
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [1:0]                   addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [W-1:0]                 evt_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [W/2-1:0][FIELD_W-1:0]  fields_o,
  output logic [W-1:0]                 mask_o,
  output logic [W-1:0]                 pend_o
);
  localparam logic [DATA_W-1:0] CFG_A_MASK = cfg_valid(CFG_A_FIELDS);
  localparam logic [DATA_W-1:0] CFG_B_MASK = cfg_valid(CFG_B_FIELDS);

  logic [DATA_W-1:0] cfg_a_q, cfg_b_q, rdata_q, rd_mux;
  logic [W-1:0]      mask_q, pend_q, clr;
  logic              wr, rd;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign clr = (wr && sel == REG_PEND) ? wdata_i[W-1:0] : '0;

  always_comb begin
    unique case (sel)
      REG_CFG_A: rd_mux = cfg_a_q;
      REG_CFG_B: rd_mux = cfg_b_q;
      REG_MASK:  rd_mux = DATA_W'(mask_q);
      default:   rd_mux = DATA_W'(pend_q);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && sel == REG_CFG_A) cfg_a_q <= wdata_i & CFG_A_MASK;
      if (wr && sel == REG_CFG_B) cfg_b_q <= wdata_i & CFG_B_MASK;
      if (wr && sel == REG_MASK)  mask_q  <= wdata_i[W-1:0];
      // event has priority over a simultaneous clear
      pend_q <= (pend_q & ~clr) | evt_i;
      if (rd) rdata_q <= rd_mux;
    end
  end

  for (genvar f = 0; f < W/2; f++) begin : g_field
    if (f < CFG_A_FIELDS) begin : g_a
      assign fields_o[f] = cfg_a_q[f*FIELD_STRIDE +: FIELD_W];
    end else begin : g_b
      assign fields_o[f] = cfg_b_q[(f-CFG_A_FIELDS)*FIELD_STRIDE +: FIELD_W];
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/eint_group.sv
module eint_group
  import eint_pkg::*;
#(
  parameter int W = NUM_LINES
) (
  input  logic [W-1:0]          pend_i,
  input  logic [W-1:0]          mask_i,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [W-1:0] act;
  assign act = pend_i & ~mask_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int HI = grp_hi(g);
    assign irq_o[g] = |act[HI:LO];
  end
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  lines_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [NUM_LINES-1:0]                 lvl, evt, mask_q, pend_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   fields;

  eint_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(lines_i), .q_o(lvl)
  );

  eint_detect #(.W(NUM_LINES)) u_detect (
    .clk_i, .rst_ni, .lvl_i(lvl), .fields_i(fields), .evt_o(evt)
  );

  eint_regs #(.W(NUM_LINES)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .evt_i(evt), .rdata_o, .fields_o(fields), .mask_o(mask_q), .pend_o(pend_q)
  );

  eint_group #(.W(NUM_LINES)) u_group (
    .pend_i(pend_q), .mask_i(mask_q), .irq_o
  );
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk
  import eint_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [1:0]            addr_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [NUM_LINES-1:0]  evt,
  input logic [NUM_LINES-1:0]  mask_q,
  input logic [NUM_LINES-1:0]  pend_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(req_i && !we_i)) |-> $stable(rdata_o));

  p_evt_sets_pend_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (($past(evt) & ~pend_q) == '0));

  p_pend_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(req_i && we_i && addr_i == 2'd3)) |->
      (($past(pend_q) & ~pend_q) == '0));

  p_masked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~mask_q) == '0) |-> (irq_o == '0));

  p_irq_needs_active_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ((pend_q & ~mask_q) != '0));
endmodule

bind eint_ctrl eint_ctrl_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .rdata_o, .irq_o,
  .evt, .mask_q, .pend_q
);

// File: tb/eint_ctrl_bench.sv
module eint_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] lines_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk_i = ~clk_i;

  eint_ctrl u_eint_ctrl (.*);

  // monitor: compares read data the cycle after a read request
  always @(posedge clk_i) rd_seen <= req_i && !we_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata_o, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] e, input string t);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i);
    req_i = 1'b0;
    tick(1);
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
    end
  endtask

  function automatic logic [3:0] grp_of(input int n);
    if (n < 4)  return 4'b0001;
    if (n < 12) return 4'b0010;
    if (n < 20) return 4'b0100;
    return 4'b1000;
  endfunction

  initial begin
    int probe [8] = '{0, 3, 4, 11, 12, 19, 20, 27};
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    chk_irq(4'b0000, "R1 irq after reset");
    bus_rd(2'd0, 32'h0, "R1 cfg A reset");
    bus_rd(2'd1, 32'h0, "R1 cfg B reset");
    bus_rd(2'd2, 32'h0FFF_FFFF, "R1 mask reset");
    // R2 spare bits read zero
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd0, 32'h7777_7777, "R2 cfg A spare bits");
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, 32'h0077_7777, "R2 cfg B spare bits");
    // all lines rising-edge
    bus_wr(2'd0, 32'h4444_4444);
    bus_wr(2'd1, 32'h0044_4444);
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_rd(2'd3, 32'h0, "R2 pend cleared, upper bits zero");
    bus_wr(2'd2, 32'h0);
    // R3 latency
    lines_i[0] = 1'b1;
    tick(2);
    chk_irq(4'b0000, "R3 not yet after two edges");
    tick(1);
    chk_irq(4'b0001, "R3 visible on third edge");
    lines_i[0] = 1'b0;
    tick(4);
    bus_rd(2'd3, 32'h1, "R4 fall ignored in rise mode");
    bus_wr(2'd3, 32'h1);
    // R11 group mapping, R4 rise
    foreach (probe[k]) begin
      int n;
      n = probe[k];
      lines_i[n] = 1'b1;
      tick(3);
      chk_irq(grp_of(n), $sformatf("R11 line %0d group", n));
      bus_rd(2'd3, 32'h1 << n, $sformatf("R4 rise line %0d", n));
      lines_i[n] = 1'b0;
      tick(3);
      bus_wr(2'd3, 32'h1 << n);
      chk_irq(4'b0000, $sformatf("R9 line %0d cleared", n));
    end
    // R9 write-one-to-clear
    lines_i[1:0] = 2'b11;
    tick(3);
    bus_wr(2'd3, 32'h0);
    bus_rd(2'd3, 32'h3, "R9 zero write keeps bits");
    bus_wr(2'd3, 32'h2);
    bus_rd(2'd3, 32'h1, "R9 one write clears only that bit");
    bus_wr(2'd3, 32'h1);
    bus_rd(2'd3, 32'h0, "R9 all cleared");
    lines_i[1:0] = 2'b00;
    tick(3);
    // R5/R12 falling on pair 8/9, R7 high level on line 7
    bus_wr(2'd0, 32'h4442_1444);
    lines_i[8] = 1'b1;
    tick(4);
    bus_rd(2'd3, 32'h0, "R5 rise ignored in fall mode, line 8 shares field");
    lines_i[8] = 1'b0;
    tick(3);
    bus_rd(2'd3, 32'h100, "R5 fall sets line 8");
    bus_wr(2'd3, 32'h100);
    lines_i[9] = 1'b1;
    tick(3);
    lines_i[9] = 1'b0;
    tick(3);
    bus_rd(2'd3, 32'h200, "R12 line 9 follows shared fall field");
    bus_wr(2'd3, 32'h200);
    lines_i[7] = 1'b1;
    tick(3);
    bus_wr(2'd3, 32'h80);
    bus_rd(2'd3, 32'h80, "R7 clear ineffective while high");
    lines_i[7] = 1'b0;
    tick(4);
    bus_wr(2'd3, 32'h80);
    bus_rd(2'd3, 32'h0, "R7 clear after input low");
    // R6 both edges on line 20, R8/R12 low level on pair 26/27
    bus_wr(2'd1, 32'h0044_4644);
    lines_i[20] = 1'b1;
    tick(3);
    bus_rd(2'd3, 32'h10_0000, "R6 rise sets line 20");
    bus_wr(2'd3, 32'h10_0000);
    lines_i[20] = 1'b0;
    tick(3);
    bus_rd(2'd3, 32'h10_0000, "R6 fall sets line 20");
    bus_wr(2'd3, 32'h10_0000);
    bus_wr(2'd1, 32'h0004_4644);
    tick(1);
    bus_wr(2'd3, 32'h0C00_0000);
    bus_rd(2'd3, 32'h0C00_0000, "R8 low level re-sets lines 26 and 27");
    lines_i[27:26] = 2'b11;
    tick(3);
    bus_wr(2'd3, 32'h0C00_0000);
    bus_rd(2'd3, 32'h0, "R8 clear once inputs high");
    // R10 mask
    bus_wr(2'd2, 32'h1000);
    lines_i[12] = 1'b1;
    tick(3);
    chk_irq(4'b0000, "R10 masked line silent");
    bus_rd(2'd3, 32'h1000, "R10 masked line still pending");
    bus_wr(2'd2, 32'h0);
    chk_irq(4'b0100, "R10 unmask releases held event");
    bus_wr(2'd3, 32'h1000);
    lines_i[12] = 1'b0;
    tick(3);
    // R13 event wins over clear
    lines_i[5] = 1'b1;
    tick(3);
    lines_i[5] = 1'b0;
    tick(3);
    lines_i[5] = 1'b1;
    tick(2);
    bus_wr(2'd3, 32'h20);
    bus_rd(2'd3, 32'h20, "R13 event wins over same-cycle clear");
    bus_wr(2'd3, 32'h20);
    bus_rd(2'd3, 32'h0, "R13 later clear works");
    chk_irq(4'b0000, "R11 all outputs idle");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule